// File: doc/BRIEF.md
# Synchronizable Dual-Port Sample Demultiplexer

This block is the digital back end of a fast sampling front end. On every rising edge of the sample clock it captures one input word and carries it through a fixed pipeline. A mode input picks one of two delivery schemes. In single-port mode every word leaves on port A. In dual-port mode the words are dealt out alternately to port A and port B, so each port changes at half the sample rate and holds each word for two clock periods.

The dealing is done by an internal divide-by-two. Its phase after reset is loaded from the parity of a seed input, so which port carries the even words is not known in advance. A falling edge on the alignment input fixes that phase: the first word captured after the edge that sees the fall goes to port A. A fall that arrives when the divider already has that phase changes nothing. A fall that arrives in the opposite phase makes the divider slip one word, and the two words on either side of the slip (one per port) are marked by a corruption flag. A square wave at half the sample rate on the alignment input therefore keeps the block aligned, with no further corruption after the first fall.

Top module: `dual_port_splitter`

## Requirements
- R1: While `rst` is high, and for the first four clock cycles after it falls, `port_a` and `port_b` read zero and `a_valid`, `b_valid` and `corrupt` stay low.
- R2: With `single_mode` high, the word on `din` at rising edge n is on `port_a` right after rising edge n+4, with `a_valid` high for that cycle.
- R3: With `single_mode` high, `port_b` keeps its value, `b_valid` stays low and `corrupt` stays low, whatever `align_in` does.
- R4: With `single_mode` low, each captured word goes to exactly one port, after the same four-edge latency; the strobe of that port is high for that one cycle, the other strobe is low, and apart from a resync consecutive words go to opposite ports.
- R5: After reset and before any alignment, the word captured at the first rising edge after reset goes to port B when the XOR of all `seed` bits is 1, and to port A when it is 0.
- R6: When `align_in` is sampled high at one rising edge after reset and low at the next (edge k), the word captured at edge k+1 goes to port A and alternation continues from there.
- R7: If the word captured at edge k was already bound for port B, the fall changes no routing and `corrupt` stays low.
- R8: If the word captured at edge k was bound for port A, the word from edge k-1 (on port B) and the word from edge k (on port A) are delivered with `corrupt` high in their strobe cycle; every other delivered word has `corrupt` low.
- R9: A square wave at half the sample rate on `align_in` keeps the routing fixed and never raises `corrupt` after the first fall.
- R10: A port whose strobe is low in a cycle does not change value in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed | input | SEED_W (8) | Start-up phase source; its bit parity picks the first port |
| din | input | SAMPLE_W (8) | Input word, captured every rising edge |
| single_mode | input | 1 | 1: all words to port A; 0: alternate between A and B |
| align_in | input | 1 | Alignment input; a falling edge fixes the divider phase |
| port_a | output | SAMPLE_W (8) | Output word, port A |
| port_b | output | SAMPLE_W (8) | Output word, port B |
| a_valid | output | 1 | One-cycle strobe when port A updates |
| b_valid | output | 1 | One-cycle strobe when port B updates |
| corrupt | output | 1 | High with a strobe when the word delivered is one of the two slip words |

## Verification
The block is driven in single-port mode with a toggling alignment input, which separates a correct four-edge latency from an off-by-one and shows that port B and the flag ignore the alignment input. In dual-port mode it runs with seeds of both parities and no alignment, which tells whether the start-up phase really follows the seed. Single alignment falls placed on an odd and on an even edge distinguish the in-phase case, which must leave the stream untouched, from the slip case, which must flag exactly one word per port. A half-rate square wave on the alignment input then checks that repeated falls leave an aligned stream alone.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_LATENCY  = 4;
    localparam int DEF_SEED_W   = 8;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_sel_e;

    typedef struct packed {
        logic      live;
        port_sel_e dest;
        logic      bad;
    } word_tag_t;

    localparam word_tag_t TAG_IDLE = '{live: 1'b0, dest: PORT_A, bad: 1'b0};

    function automatic port_sel_e other_port(input port_sel_e p);
        return (p == PORT_A) ? PORT_B : PORT_A;
    endfunction

endpackage

// File: rtl/split_phase_ctrl.sv
module split_phase_ctrl
    import splitter_pkg::*;
#(
    parameter int SEED_W = DEF_SEED_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEED_W-1:0] seed,
    input  logic              align_in,
    output port_sel_e         cur_dest,
    output logic              slip
);

    logic      align_q;
    port_sel_e next_dest;
    logic      fall_seen;

    assign fall_seen = align_q & ~align_in;
    assign cur_dest  = next_dest;
    assign slip      = fall_seen && (next_dest == PORT_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            align_q   <= 1'b0;
            next_dest <= port_sel_e'(^seed);
        end else begin
            align_q   <= align_in;
            next_dest <= fall_seen ? PORT_A : other_port(next_dest);
        end
    end

endmodule

// File: rtl/split_delay_line.sv
module split_delay_line
    import splitter_pkg::*;
#(
    parameter int W      = DEF_SAMPLE_W,
    parameter int STAGES = DEF_LATENCY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  word_tag_t    in_tag,
    input  logic         slip,
    output logic [W-1:0] dout,
    output word_tag_t    dtag
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] data_q;
        word_tag_t    tag_q;

        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q <= '0;
                    tag_q  <= TAG_IDLE;
                end else begin
                    data_q <= din;
                    tag_q  <= in_tag;
                end
            end
        end else if (g == 1) begin : g_mark
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q <= '0;
                    tag_q  <= TAG_IDLE;
                end else begin
                    data_q     <= g_stage[g-1].data_q;
                    tag_q.live <= g_stage[g-1].tag_q.live;
                    tag_q.dest <= g_stage[g-1].tag_q.dest;
                    tag_q.bad  <= g_stage[g-1].tag_q.bad | slip;
                end
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q <= '0;
                    tag_q  <= TAG_IDLE;
                end else begin
                    data_q <= g_stage[g-1].data_q;
                    tag_q  <= g_stage[g-1].tag_q;
                end
            end
        end
    end

    assign dout = g_stage[LAST].data_q;
    assign dtag = g_stage[LAST].tag_q;

endmodule

// File: rtl/split_port_router.sv
module split_port_router
    import splitter_pkg::*;
#(
    parameter int W = DEF_SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         single_mode,
    input  logic [W-1:0] word,
    input  word_tag_t    tag,
    output logic [W-1:0] port_a,
    output logic [W-1:0] port_b,
    output logic         a_valid,
    output logic         b_valid,
    output logic         corrupt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_a  <= '0;
            port_b  <= '0;
            a_valid <= 1'b0;
            b_valid <= 1'b0;
            corrupt <= 1'b0;
        end else begin
            a_valid <= 1'b0;
            b_valid <= 1'b0;
            corrupt <= 1'b0;
            if (tag.live) begin
                if (single_mode) begin
                    port_a  <= word;
                    a_valid <= 1'b1;
                end else if (tag.dest == PORT_B) begin
                    port_b  <= word;
                    b_valid <= 1'b1;
                    corrupt <= tag.bad;
                end else begin
                    port_a  <= word;
                    a_valid <= 1'b1;
                    corrupt <= tag.bad;
                end
            end
        end
    end

endmodule

// File: rtl/dual_port_splitter.sv
module dual_port_splitter
    import splitter_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int LATENCY  = DEF_LATENCY,
    parameter int SEED_W   = DEF_SEED_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEED_W-1:0]   seed,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                single_mode,
    input  logic                align_in,
    output logic [SAMPLE_W-1:0] port_a,
    output logic [SAMPLE_W-1:0] port_b,
    output logic                a_valid,
    output logic                b_valid,
    output logic                corrupt
);

    localparam int STAGES = LATENCY;

    port_sel_e             cur_dest;
    logic                  slip;
    word_tag_t             in_tag;
    logic [SAMPLE_W-1:0]   tail_word;
    word_tag_t             tail_tag;

    assign in_tag = '{live: 1'b1, dest: cur_dest, bad: slip};

    split_phase_ctrl #(.SEED_W(SEED_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .seed     (seed),
        .align_in (align_in),
        .cur_dest (cur_dest),
        .slip     (slip)
    );

    split_delay_line #(.W(SAMPLE_W), .STAGES(STAGES)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .in_tag (in_tag),
        .slip   (slip),
        .dout   (tail_word),
        .dtag   (tail_tag)
    );

    split_port_router #(.W(SAMPLE_W)) u_router (
        .clk         (clk),
        .rst         (rst),
        .single_mode (single_mode),
        .word        (tail_word),
        .tag         (tail_tag),
        .port_a      (port_a),
        .port_b      (port_b),
        .a_valid     (a_valid),
        .b_valid     (b_valid),
        .corrupt     (corrupt)
    );

endmodule

// File: rtl/split_checker.sv
module split_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         single_mode,
    input logic [W-1:0] port_a,
    input logic [W-1:0] port_b,
    input logic         a_valid,
    input logic         b_valid,
    input logic         corrupt
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst || rst_q)
        !(a_valid && b_valid));

    p_b_frozen_r3: assert property (@(posedge clk) disable iff (rst || rst_q)
        single_mode |=> ($stable(port_b) && !b_valid));

    p_no_flag_single_r3: assert property (@(posedge clk) disable iff (rst || rst_q)
        single_mode |=> !corrupt);

    p_flag_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst || rst_q)
        corrupt |-> (a_valid || b_valid));

    p_a_hold_r10: assert property (@(posedge clk) disable iff (rst || rst_q)
        !$stable(port_a) |-> a_valid);

    p_b_hold_r10: assert property (@(posedge clk) disable iff (rst || rst_q)
        !$stable(port_b) |-> b_valid);

    p_alternate_r4: assert property (@(posedge clk) disable iff (rst || rst_q)
        (!single_mode && !$past(single_mode) && a_valid && !corrupt) |=> !a_valid);

endmodule

bind dual_port_splitter split_checker #(.W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .single_mode (single_mode),
    .port_a      (port_a),
    .port_b      (port_b),
    .a_valid     (a_valid),
    .b_valid     (b_valid),
    .corrupt     (corrupt)
);

// File: tb/sim_dual_port_splitter.sv
module sim_dual_port_splitter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] seed = '0;
    logic [7:0] din = '0;
    logic       single_mode = 1'b1;
    logic       align_in = 1'b0;
    logic [7:0] port_a, port_b;
    logic       a_valid, b_valid, corrupt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_port_splitter u0 (
        .clk(clk), .rst(rst), .seed(seed), .din(din),
        .single_mode(single_mode), .align_in(align_in),
        .port_a(port_a), .port_b(port_b),
        .a_valid(a_valid), .b_valid(b_valid), .corrupt(corrupt)
    );

    // Sample-level reference, built from the requirements.
    logic [7:0] m_val [0:1023];
    logic       m_dst [0:1023];
    logic       m_bad [0:1023];
    int         cyc = 0;
    logic       m_prev_al = 0, m_fall_prev = 0, m_fall;
    logic [7:0] a_hold = 0, b_hold = 0;

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            m_prev_al = 0;
            m_fall_prev = 0;
            for (int i = 0; i < 1024; i++) m_bad[i] = 0;
        end else if (cyc < 1024) begin
            if (cyc == 0) m_dst[0] = ^seed;              // R5
            else          m_dst[cyc] = m_fall_prev ? 1'b0 : ~m_dst[cyc-1]; // R6
            m_val[cyc] = din;
            m_fall = m_prev_al && !align_in;
            if (m_fall && m_dst[cyc] == 1'b0) begin       // R8 slip
                m_bad[cyc] = 1;
                if (cyc > 0) m_bad[cyc-1] = 1;
            end
            m_fall_prev = m_fall;
            m_prev_al = align_in;
            cyc++;
        end
    end

    task automatic expect_eq(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; outputs reflect the last rising edge.
    task automatic check_out(input string rq);
        int n;
        n = cyc - 5;
        if (n < 0) begin
            expect_eq("R1", "a_valid", a_valid, 0);
            expect_eq("R1", "b_valid", b_valid, 0);
            expect_eq("R1", "corrupt", corrupt, 0);
            expect_eq("R1", "port_a", port_a, a_hold);
            expect_eq("R1", "port_b", port_b, b_hold);
        end else if (single_mode) begin
            expect_eq("R2", "a_valid", a_valid, 1);
            expect_eq("R2", "port_a", port_a, m_val[n]);
            expect_eq("R3", "b_valid", b_valid, 0);
            expect_eq("R3", "port_b", port_b, b_hold);
            expect_eq("R3", "corrupt", corrupt, 0);
            a_hold = m_val[n];
        end else if (m_dst[n]) begin
            expect_eq(rq, "b_valid", b_valid, 1);
            expect_eq(rq, "a_valid", a_valid, 0);
            expect_eq(rq, "port_b", port_b, m_val[n]);
            expect_eq("R10", "port_a held", port_a, a_hold);
            expect_eq(rq, "corrupt", corrupt, m_bad[n]);
            b_hold = m_val[n];
        end else begin
            expect_eq(rq, "a_valid", a_valid, 1);
            expect_eq(rq, "b_valid", b_valid, 0);
            expect_eq(rq, "port_a", port_a, m_val[n]);
            expect_eq("R10", "port_b held", port_b, b_hold);
            expect_eq(rq, "corrupt", corrupt, m_bad[n]);
            a_hold = m_val[n];
        end
    endtask

    task automatic tick(input logic [7:0] d, input logic al, input string rq);
        din = d;
        align_in = al;
        @(negedge clk);
        check_out(rq);
    endtask

    task automatic do_reset(input logic [7:0] s, input logic mode);
        @(negedge clk);
        rst = 1;
        seed = s;
        single_mode = mode;
        align_in = 0;
        a_hold = 0;
        b_hold = 0;
        repeat (2) begin
            @(negedge clk);
            check_out("R1");
        end
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset(8'h5A, 1'b0);
        for (int i = 0; i < 4; i++) tick(8'(i * 29 + 7), 1'b0, "R1");
    endtask

    task automatic t_single();
        do_reset(8'h03, 1'b1);
        for (int i = 0; i < 24; i++) tick(8'(i * 37 + 11), 1'(i % 3 == 0), "R2");
    endtask

    task automatic t_startup(input logic [7:0] s);
        do_reset(s, 1'b0);
        for (int i = 0; i < 16; i++) tick(8'(i * 53 + 5), 1'b0, "R5");
    endtask

    task automatic t_sync(input int k, input string rq);
        do_reset(8'h00, 1'b0);
        for (int i = 0; i < k + 14; i++) tick(8'(i * 41 + 19), 1'(i < k), rq);
    endtask

    task automatic t_square();
        do_reset(8'h01, 1'b0);
        for (int i = 0; i < 40; i++) tick(8'(i * 23 + 3), 1'(i % 2), "R9");
    endtask

    initial begin
        t_reset();                 // R1
        t_single();                // R2 R3
        t_startup(8'h00);          // R5 even parity
        t_startup(8'h07);          // R5 odd parity
        t_sync(11, "R7");          // fall on edge already bound for B
        t_sync(10, "R8");          // fall on edge bound for A: slip
        t_sync(14, "R6");
        t_square();                // R9
        t_single();                // R2 after dual runs
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule